// File: doc/BRIEF.md
# Three-Requester Rule-Table Arbiter

This block grants one of three requesters. It samples a three-bit request vector on each rising clock edge. A fixed rule table maps that sample to one of four states: no grant, or a grant to requester 0, 1 or 2. The grant outputs come straight from the registered state, so a grant appears one clock after its request pattern is sampled. Each decision depends only on the latest sample. The block keeps no memory of earlier grants and makes no attempt at fairness.

The rule table is not a priority encoder:

- A lone request always wins.
- Requesters 0 and 1 together give the grant to 0. This holds whether or not requester 2 is also asking.
- Requesters 1 and 2 without 0 give the grant to 1.
- Requesters 0 and 2 without 1 give the grant to 2.

No request at all returns the block to the no-grant state.

Top module: `arb3_top`

## Requirements
- R1: Reset is synchronous and active high. At the first rising edge where rst is 1, grantVec becomes 3'b000. It stays 3'b000 for as long as rst stays 1, whatever reqVec carries.
- R2: When reqVec is 3'b000 at a rising edge with rst low, grantVec is 3'b000 after that edge.
- R3: When exactly one bit of reqVec is set at an edge, grantVec after that edge equals reqVec. Bit i of either vector belongs to requester i.
- R4: When reqVec bits 0 and 1 are both set at an edge, grantVec is 3'b001 after that edge, whatever bit 2 holds.
- R5: When reqVec is 3'b110 at an edge, grantVec is 3'b010 after that edge.
- R6: When reqVec is 3'b101 at an edge, grantVec is 3'b100 after that edge.
- R7: At most one bit of grantVec is ever set.
- R8: grantVec after an edge depends only on the reqVec sampled at that edge. A previous grant has no effect, and the grant holds steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| reqVec | input | 3 | Request vector, bit i is requester i |
| grantVec | output | 3 | Registered one-hot-or-zero grant, bit i is requester i |

## Verification
A wrong state register or a wrong rule-table entry shows up on grantVec in the cycle right after the faulty pattern is sampled. Because the state carries no history, every sample is a complete, self-contained test of one row of the table. A stuck or mis-decoded state can therefore hide for no more than one cycle after its row is exercised. The directed sweep visits all eight rows, including both the idle row and the all-request row, and the random stretch visits them again from every possible prior grant. Any dependence on the previous grant would therefore surface.

// File: rtl/arb3_pkg.sv
package arb3_pkg;
  localparam int NUM_REQ = 3;
  localparam int STATE_W = $clog2(NUM_REQ + 1);

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,
    ST_G0   = 2'd1,
    ST_G1   = 2'd2,
    ST_G2   = 2'd3
  } arbState_t;

  // Strobes from control to the grant register
  typedef struct packed {
    logic               clearAll;
    logic [NUM_REQ-1:0] pickOneHot;
  } grantStrobe_t;
endpackage

// File: rtl/arb3_ctrl.sv
module arb3_ctrl
  import arb3_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqVec,
  output grantStrobe_t       strobe
);
  arbState_t curState;
  arbState_t nextState;

  // Rule table: the pairing rule for 0/1 is checked before the 1/2 rule
  always_comb begin
    unique case (reqVec)
      3'b000:  nextState = ST_IDLE;
      3'b001:  nextState = ST_G0;
      3'b010:  nextState = ST_G1;
      3'b100:  nextState = ST_G2;
      3'b011,
      3'b111:  nextState = ST_G0;
      3'b110:  nextState = ST_G1;
      default: nextState = ST_G2;   // 3'b101
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  assign strobe.clearAll = rst || (nextState == ST_IDLE);

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_pick
    assign strobe.pickOneHot[i] = (nextState == arbState_t'(i + 1));
  end

  AST_RULE_IDLE:  assert property (@(posedge clk) disable iff (rst)
    reqVec == 3'b000 |=> curState == ST_IDLE);                       // R2
  AST_RULE_PAIR01: assert property (@(posedge clk) disable iff (rst)
    (reqVec[0] && reqVec[1]) |=> curState == ST_G0);                 // R4
  AST_RULE_PAIR12: assert property (@(posedge clk) disable iff (rst)
    reqVec == 3'b110 |=> curState == ST_G1);                         // R5
  AST_RULE_PAIR02: assert property (@(posedge clk) disable iff (rst)
    reqVec == 3'b101 |=> curState == ST_G2);                         // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> curState == ST_IDLE);                                    // R1
endmodule

// File: rtl/arb3_grant_reg.sv
module arb3_grant_reg
  import arb3_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  grantStrobe_t       strobe,
  output logic [NUM_REQ-1:0] grantVec
);
  always_ff @(posedge clk) begin
    if (strobe.clearAll) grantVec <= '0;
    else                 grantVec <= strobe.pickOneHot;
  end

  AST_ONE_GRANT:    assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec));                                             // R7
  AST_RESET_CLEAR:  assert property (@(posedge clk)
    rst |=> grantVec == '0);                                         // R1
  AST_STEADY:       assert property (@(posedge clk) disable iff (rst)
    strobe.clearAll |=> grantVec == '0);                             // R2
endmodule

// File: rtl/arb3_top.sv
module arb3_top
  import arb3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reqVec,
  output logic [2:0] grantVec
);
  grantStrobe_t strobe;

  arb3_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .reqVec (reqVec),
    .strobe (strobe)
  );

  arb3_grant_reg u_grant (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .grantVec (grantVec)
  );

  AST_SINGLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $onehot(reqVec) |=> grantVec == $past(reqVec));                  // R3
endmodule

// File: tb/arb3_top_tb.sv
module arb3_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reqVec = 3'b000;
  logic [2:0] grantVec;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  arb3_top u_dut (.clk(clk), .rst(rst), .reqVec(reqVec), .grantVec(grantVec));

  function automatic logic [2:0] expGrant(input logic [2:0] r);
    if (r == 3'b000)             return 3'b000;
    if ($countones(r) == 1)      return r;
    if (r[0] && r[1])            return 3'b001;
    if (r[1] && r[2])            return 3'b010;
    return 3'b100;
  endfunction

  function automatic string reqTag(input logic [2:0] r);
    if (r == 3'b000)        return "R2";
    if ($countones(r) == 1) return "R3";
    if (r[0] && r[1])       return "R4";
    if (r == 3'b110)        return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if (grantVec !== exp) begin
      errors++;
      $display("FAIL %s: grantVec=%b expected=%b", tag, grantVec, exp);
    end
    if ($countones(grantVec) > 1) begin
      errors++;
      $display("FAIL R7: grantVec=%b expected at most one bit", grantVec);
    end
  endtask

  // Drive at negedge, edge samples it, check at next negedge
  task automatic step(input logic [2:0] r);
    reqVec = r;
    @(negedge clk);
    check(reqTag(r), expGrant(r));
  endtask

  initial begin
    logic [2:0] r;
    @(negedge clk);
    @(negedge clk);
    check("R1", 3'b000);
    reqVec = 3'b111;
    @(negedge clk);
    check("R1", 3'b000);              // R1: requests ignored under reset
    rst = 1'b0;
    for (int i = 0; i < 8; i++) step(3'(i));
    for (int i = 7; i >= 0; i--) step(3'(i));
    // R8: every pattern from every prior grant
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(3'(a));
        step(3'(b));
      end
    // R8: grant steady between edges
    reqVec = 3'b110;
    @(negedge clk);
    #3;
    checks++;
    if (grantVec !== 3'b010) begin
      errors++;
      $display("FAIL R8: grantVec=%b expected=%b", grantVec, 3'b010);
    end
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      r = 3'($urandom);
      step(r);
    end
    // R1: mid-traffic reset
    reqVec = 3'b101;
    rst = 1'b1;
    @(negedge clk);
    check("R1", 3'b000);
    rst = 1'b0;
    step(3'b101);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule